// File: doc/BRIEF.md
# Sectioned Accumulator Result Register with Pin Preload

This block is the output stage of a 35-bit multiply-accumulate datapath. It holds the accumulator value in three independently controlled sections: a 16-bit low section (bits 15-0), a 16-bit high section (bits 31-16) and a 3-bit extension section (bits 34-32). Each section drives its own group of output pins. The block models the tri-state pins as separate data-out, data-in and drive-enable signals, one set per section.

Each section has one active-high "quiet" control with two jobs. When the preload control is low, the quiet control decides whether the section drives its pins. When preload is high, no section drives, and every quiet section is loaded from its own pins on the result strobe instead of from the datapath. The register's full value is fed back to the datapath, so preloaded contents become the starting value of the next accumulate or subtract. The low section's pins are shared with the B operand input. Whatever is seen on those pins is passed straight through as the B operand.

Top module: `result_bank`

## Requirements
- R1: While reset is asserted, all 35 bits of `acc_q` are 0. Each pin output shows 0 until the first strobe.
- R2: With `preload` at 0, the drive enable of a section is 1 when its quiet control is 0, and 0 when its quiet control is 1. Each section is decided by its own control only.
- R3: With `preload` at 1, all three drive enables are 0 for every value of the quiet controls.
- R4: On a clock edge with `res_stb` at 1 and `preload` at 1, each section whose quiet control is 1 loads the value on its own pin input.
- R5: On a clock edge with `res_stb` at 1, each section not loaded under R4 takes its slice of `acc_next`: low is bits 15-0, high is bits 31-16, extension is bits 34-32.
- R6: On a clock edge with `res_stb` at 0, all sections keep their value, whatever the other controls and pins are.
- R7: `pin_out_lo`, `pin_out_hi` and `pin_out_ex` always show bits 15-0, 31-16 and 34-32 of the held value. `acc_q` presents the full held value to the datapath.
- R8: `b_operand` always equals `pin_in_lo`.
- R9: All 16 combinations of `preload` and the three quiet controls are decoded as R2 to R5 state, per section and without interaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_stb | input | 1 | Result strobe; the register updates only on edges where this is 1 |
| preload | input | 1 | Preload control |
| quiet_ex | input | 1 | Extension section: release the pins / select for preload |
| quiet_hi | input | 1 | High section: release the pins / select for preload |
| quiet_lo | input | 1 | Low section: release the pins / select for preload |
| acc_next | input | 35 | Next accumulator value from the datapath |
| pin_in_ex | input | 3 | Value seen on the extension pins |
| pin_in_hi | input | 16 | Value seen on the high pins |
| pin_in_lo | input | 16 | Value seen on the low pins (shared with B operand) |
| pin_out_ex | output | 3 | Extension section data to the pins |
| pin_out_hi | output | 16 | High section data to the pins |
| pin_out_lo | output | 16 | Low section data to the pins |
| drv_ex | output | 1 | Extension pins drive enable |
| drv_hi | output | 1 | High pins drive enable |
| drv_lo | output | 1 | Low pins drive enable |
| acc_q | output | 35 | Held accumulator value fed back to the datapath |
| b_operand | output | 16 | B operand taken from the shared low pins |

## Verification
The bench builds the block with its default widths of 16, 16 and 3. This exposes the two section boundaries at bits 16 and 32, so a slice placed one bit off shows up in the expected values. All 16 control combinations are walked with pin and datapath patterns that differ in every section, so a section taking the wrong source or the wrong control is visible. Random cycles then mix strobe-off edges, which must hold the value, with preloads and datapath loads.

// File: rtl/result_bank.sv
module result_bank #(
  parameter int LO_W = 16,
  parameter int HI_W = 16,
  parameter int EX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     res_stb,
  input  logic                     preload,
  input  logic                     quiet_ex,
  input  logic                     quiet_hi,
  input  logic                     quiet_lo,
  input  logic [LO_W+HI_W+EX_W-1:0] acc_next,
  input  logic [EX_W-1:0]          pin_in_ex,
  input  logic [HI_W-1:0]          pin_in_hi,
  input  logic [LO_W-1:0]          pin_in_lo,
  output logic [EX_W-1:0]          pin_out_ex,
  output logic [HI_W-1:0]          pin_out_hi,
  output logic [LO_W-1:0]          pin_out_lo,
  output logic                     drv_ex,
  output logic                     drv_hi,
  output logic                     drv_lo,
  output logic [LO_W+HI_W+EX_W-1:0] acc_q,
  output logic [LO_W-1:0]          b_operand
);
  localparam int TOT_W = LO_W + HI_W + EX_W;

  logic [2:0]       quiet_v;
  logic [2:0]       drv_v;
  logic [TOT_W-1:0] pin_v;
  logic [TOT_W-1:0] acc_d;
  logic [TOT_W-1:0] acc_r;

  assign quiet_v = {quiet_ex, quiet_hi, quiet_lo};
  assign pin_v   = {pin_in_ex, pin_in_hi, pin_in_lo};

  for (genvar g = 0; g < 3; g++) begin : g_sec
    localparam int LSB = (g == 0) ? 0 : (g == 1) ? LO_W : LO_W + HI_W;
    localparam int W   = (g == 0) ? LO_W : (g == 1) ? HI_W : EX_W;
    logic take_pin;
    assign take_pin       = preload & quiet_v[g];
    assign acc_d[LSB+:W]  = take_pin ? pin_v[LSB+:W] : acc_next[LSB+:W];
    assign drv_v[g]       = ~preload & ~quiet_v[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_r <= '0;
    else if (res_stb) acc_r <= acc_d;
  end

  assign pin_out_lo = acc_r[LO_W-1:0];
  assign pin_out_hi = acc_r[LO_W+HI_W-1:LO_W];
  assign pin_out_ex = acc_r[TOT_W-1:LO_W+HI_W];
  assign {drv_ex, drv_hi, drv_lo} = drv_v;
  assign acc_q      = acc_r;
  assign b_operand  = pin_in_lo;
endmodule

module result_bank_chk #(
  parameter int LO_W = 16,
  parameter int HI_W = 16,
  parameter int EX_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      res_stb,
  input logic                      preload,
  input logic                      quiet_ex,
  input logic                      quiet_hi,
  input logic                      quiet_lo,
  input logic [LO_W+HI_W+EX_W-1:0] acc_next,
  input logic [EX_W-1:0]           pin_in_ex,
  input logic [HI_W-1:0]           pin_in_hi,
  input logic [LO_W-1:0]           pin_in_lo,
  input logic [EX_W-1:0]           pin_out_ex,
  input logic [HI_W-1:0]           pin_out_hi,
  input logic [LO_W-1:0]           pin_out_lo,
  input logic                      drv_ex,
  input logic                      drv_hi,
  input logic                      drv_lo,
  input logic [LO_W+HI_W+EX_W-1:0] acc_q,
  input logic [LO_W-1:0]           b_operand
);
  localparam int TOT_W = LO_W + HI_W + EX_W;

  always_comb begin
    if (!rst_n) p_reset_clear_r1: assert (acc_q == '0);
  end

  p_quiet_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_lo |-> !drv_lo) and (quiet_hi |-> !drv_hi) and (quiet_ex |-> !drv_ex));

  p_preload_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    preload |-> (!drv_lo && !drv_hi && !drv_ex));

  p_preload_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_stb && preload && quiet_lo) |=> pin_out_lo == $past(pin_in_lo));

  p_preload_ex_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_stb && preload && quiet_ex) |=> pin_out_ex == $past(pin_in_ex));

  p_datapath_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_stb && !(preload && quiet_hi)) |=> pin_out_hi == $past(acc_next[LO_W+HI_W-1:LO_W]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_stb |=> $stable(acc_q));

  p_pins_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q == {pin_out_ex, pin_out_hi, pin_out_lo});

  p_b_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    b_operand == pin_in_lo);
endmodule

bind result_bank result_bank_chk #(.LO_W(LO_W), .HI_W(HI_W), .EX_W(EX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_stb(res_stb), .preload(preload),
  .quiet_ex(quiet_ex), .quiet_hi(quiet_hi), .quiet_lo(quiet_lo),
  .acc_next(acc_next), .pin_in_ex(pin_in_ex), .pin_in_hi(pin_in_hi),
  .pin_in_lo(pin_in_lo), .pin_out_ex(pin_out_ex), .pin_out_hi(pin_out_hi),
  .pin_out_lo(pin_out_lo), .drv_ex(drv_ex), .drv_hi(drv_hi), .drv_lo(drv_lo),
  .acc_q(acc_q), .b_operand(b_operand)
);

// File: tb/test_result_bank.sv
module test_result_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        res_stb = 0, preload = 0;
  logic        quiet_ex = 0, quiet_hi = 0, quiet_lo = 0;
  logic [34:0] acc_next = '0;
  logic [2:0]  pin_in_ex = '0;
  logic [15:0] pin_in_hi = '0, pin_in_lo = '0;
  logic [2:0]  pin_out_ex;
  logic [15:0] pin_out_hi, pin_out_lo, b_operand;
  logic        drv_ex, drv_hi, drv_lo;
  logic [34:0] acc_q;

  int n_run = 0, n_fail = 0;
  logic [34:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  result_bank i_result_bank (
    .clk(clk), .rst_n(rst_n), .res_stb(res_stb), .preload(preload),
    .quiet_ex(quiet_ex), .quiet_hi(quiet_hi), .quiet_lo(quiet_lo),
    .acc_next(acc_next), .pin_in_ex(pin_in_ex), .pin_in_hi(pin_in_hi),
    .pin_in_lo(pin_in_lo), .pin_out_ex(pin_out_ex), .pin_out_hi(pin_out_hi),
    .pin_out_lo(pin_out_lo), .drv_ex(drv_ex), .drv_hi(drv_hi), .drv_lo(drv_lo),
    .acc_q(acc_q), .b_operand(b_operand)
  );

  function automatic logic [2:0] exp_drv(logic pl, logic [2:0] q);
    return pl ? 3'b000 : ~q;
  endfunction

  function automatic logic [34:0] exp_next(logic [34:0] cur, logic [34:0] dp,
      logic [34:0] pins, logic stb, logic pl, logic [2:0] q);
    logic [34:0] r = cur;
    if (stb) begin
      r[15:0]  = (pl && q[0]) ? pins[15:0]  : dp[15:0];
      r[31:16] = (pl && q[1]) ? pins[31:16] : dp[31:16];
      r[34:32] = (pl && q[2]) ? pins[34:32] : dp[34:32];
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [2:0] q = {quiet_ex, quiet_hi, quiet_lo};
    #1;
    check({tag, " R2/R3 drive"}, {drv_ex, drv_hi, drv_lo}, exp_drv(preload, q));
    check("R8 b_operand", b_operand, pin_in_lo);
    model = exp_next(model, acc_next, {pin_in_ex, pin_in_hi, pin_in_lo},
                     res_stb, preload, q);
    @(posedge clk); #1;
    check({tag, " R4/R5/R6 acc_q"}, acc_q, model);
    check("R7 pins", {pin_out_ex, pin_out_hi, pin_out_lo}, model);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    check("R1 reset acc_q", acc_q, 35'd0);
    @(posedge clk); #1;
    check("R1 reset pins", {pin_out_ex, pin_out_hi, pin_out_lo}, 35'd0);
    rst_n = 1;
    @(posedge clk); #1;
    // R9: walk all 16 control combinations, distinct patterns per section
    for (int c = 0; c < 16; c++) begin
      {preload, quiet_ex, quiet_hi, quiet_lo} = 4'(c);
      res_stb   = 1;
      acc_next  = {3'(c + 1), 16'hA000 + 16'(c), 16'h0A00 + 16'(c)};
      pin_in_ex = 3'(~c);
      pin_in_hi = 16'h5100 + 16'(c);
      pin_in_lo = 16'h0051 + 16'(c << 8);
      step("R9");
    end
    // R6: strobe off with preload active must not change anything
    res_stb = 0; preload = 1; {quiet_ex, quiet_hi, quiet_lo} = 3'b111;
    pin_in_lo = 16'hFFFF; pin_in_hi = 16'hFFFF; pin_in_ex = 3'h7;
    acc_next = '1;
    step("R6 hold");
    // R4 boundary: all-ones preload then all-zero datapath
    res_stb = 1;
    step("R4 ones");
    preload = 0; acc_next = '0;
    step("R5 zeros");
    for (int i = 0; i < 400; i++) begin
      res_stb   = ($urandom % 4) != 0;
      preload   = $urandom % 2;
      {quiet_ex, quiet_hi, quiet_lo} = 3'($urandom);
      acc_next  = {3'($urandom), 32'($urandom)};
      pin_in_ex = 3'($urandom);
      pin_in_hi = 16'($urandom);
      pin_in_lo = 16'($urandom);
      step("rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule